// File: doc/BRIEF.md
# Timeslot Idle Code Filler

This block sits in the transmit data path of a 32-timeslot framer, ahead of line coding. A serial bitstream enters one bit per active bit-clock enable, with a strobe marking the first bit of each 256-bit frame. For every timeslot that the host has selected, the filler replaces the timeslot's eight bits with one shared 8-bit idle pattern. All other timeslots pass through unchanged. The result leaves through a single output register.

The host reaches five byte registers through a simple write port with a combinational read-back. One register holds the idle pattern. Four registers hold the 32 per-timeslot select bits. A small state machine tracks alignment. It starts in `ST_HUNT`, where every bit passes through untouched. The first frame strobe moves it to `ST_ALIGNED` (transition `SYNC_SEEN`). There, a bit counter gives the timeslot number and the bit position within the octet. A strobe in `ST_ALIGNED` restarts the count (transition `RESYNC`). Only a reset returns the machine to `ST_HUNT`.

Top module: `tslot_idle_fill`

## Requirements
- R1: The frame holds 32 timeslots of 8 bits. When a timeslot's select bit is 1, its octet is replaced by the idle pattern. When the select bit is 0, its octet passes through bit for bit.
- R2: Timeslot k (1..32) is selected by bit (k-1) mod 8 of the register at address 0x24 + (k-1) div 8. So 0x24 bit 0 is timeslot 1 and 0x27 bit 7 is timeslot 32.
- R3: The idle pattern register is at address 0x23. All selected timeslots use the same pattern.
- R4: Within a substituted octet, the i-th bit sent (i = 0 first) is bit 7-i of the pattern, so the MSB goes first and the LSB last.
- R5: An enabled bit with `frame_sync` high is bit 0 of timeslot 1. Later enabled bits count upward and wrap after 256. Another strobe at any point restarts the count.
- R6: After reset and before the first strobe (`ST_HUNT`), every bit passes through unchanged.
- R7: Reset clears all five registers to zero, so nothing is substituted. Reads return each register's value.
- R8: The select bit and the pattern are sampled on the first bit of each octet. A host write that lands later in that octet takes effect from the next octet.
- R9: `tx_out` changes only on the edge where `bit_en` is high. It then shows the result for the bit presented on that edge. With `bit_en` low it holds.
- R10: A write to an address outside 0x23..0x27 changes no register, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit-clock enable; one serial bit per high cycle |
| frame_sync | input | 1 | Marks the first bit of a frame (with bit_en) |
| tx_in | input | 1 | Serial transmit data in |
| host_we | input | 1 | Host write strobe |
| host_addr | input | 8 | Host register address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read-back of the addressed register |
| tx_out | output | 1 | Serial transmit data out, one enabled bit late |

## Verification
The stream is driven with random payload under several select masks: none, all, alternating, single edge timeslots 1 and 32, and random. These show whether each select bit reaches the right timeslot and whether idle data is confused with passed data. Changing the pattern between frames, and using patterns like 0x80 and 0x01, exposes bit-order and shared-code errors. Writes placed mid-octet and exactly on an octet's first bit separate boundary sampling from immediate use. Gaps in `bit_en`, a mid-frame re-strobe and a pre-strobe stretch test hold, realignment and the hunt pass-through.

// File: rtl/tsi_pkg.sv
package tsi_pkg;
    localparam int unsigned NUM_SLOTS  = 32;
    localparam int unsigned SLOT_BITS  = 8;
    localparam int unsigned NUM_MASKS  = NUM_SLOTS / 8;
    localparam logic [7:0] ADDR_CODE   = 8'h23;
    localparam logic [7:0] ADDR_MASK0  = 8'h24;

    typedef enum logic [0:0] {
        ST_HUNT    = 1'b0,
        ST_ALIGNED = 1'b1
    } align_state_t;
endpackage

// File: rtl/tsi_regs.sv
module tsi_regs
    import tsi_pkg::*;
#(
    parameter int unsigned SLOTS = NUM_SLOTS,
    parameter int unsigned WIDTH = SLOT_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [7:0]       addr,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] rdata,
    output logic [WIDTH-1:0] code,
    output logic [SLOTS-1:0] sel_mask
);
    localparam int unsigned NREG = SLOTS / 8;

    logic [7:0] mask_reg [NREG];
    logic       hit_code;

    assign hit_code = (addr == ADDR_CODE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            code <= '0;
        end else if (we && hit_code) begin
            code <= wdata;
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_mask
        logic hit;
        assign hit = (addr == ADDR_MASK0 + 8'(g));
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                mask_reg[g] <= '0;
            end else if (we && hit) begin
                mask_reg[g] <= wdata[7:0];
            end
        end
        assign sel_mask[g*8 +: 8] = mask_reg[g];
    end

    always_comb begin
        rdata = '0;
        if (hit_code) begin
            rdata = code;
        end
        for (int i = 0; i < NREG; i++) begin
            if (addr == ADDR_MASK0 + 8'(i)) begin
                rdata = WIDTH'(mask_reg[i]);
            end
        end
    end

    // R10: writes outside the map leave every register as it was
    a_r10_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && (addr < ADDR_CODE || addr > ADDR_MASK0 + 8'(NREG - 1)))
        |=> ($stable(code) && $stable(sel_mask)));

    // R3: the pattern register follows a write to its address
    a_r3_code_write: assert property (@(posedge clk) disable iff (!rst_n)
        (we && hit_code) |=> (code == $past(wdata)));
endmodule

// File: rtl/tsi_slot_ctr.sv
module tsi_slot_ctr
    import tsi_pkg::*;
#(
    parameter int unsigned SLOTS = NUM_SLOTS,
    parameter int unsigned WIDTH = SLOT_BITS
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                bit_en,
    input  logic                                frame_sync,
    output logic                                aligned,
    output logic [$clog2(SLOTS*WIDTH)-1:0]      pos
);
    localparam int unsigned FRAME_BITS = SLOTS * WIDTH;
    localparam int unsigned CNT_W      = $clog2(FRAME_BITS);

    align_state_t         state_q, state_d;
    logic [CNT_W-1:0]     cnt_q;

    // next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HUNT:    if (bit_en && frame_sync) state_d = ST_ALIGNED; // SYNC_SEEN
            ST_ALIGNED: state_d = ST_ALIGNED;                            // RESYNC / COUNT
            default:    state_d = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
        end else begin
            state_q <= state_d;
        end
    end

    // output process: position of the bit now on the input
    always_comb begin
        aligned = 1'b0;
        pos     = cnt_q;
        unique case (state_q)
            ST_HUNT: begin
                aligned = frame_sync;
                pos     = '0;
            end
            ST_ALIGNED: begin
                aligned = 1'b1;
                pos     = frame_sync ? '0 : cnt_q;
            end
            default: begin
                aligned = 1'b0;
                pos     = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (bit_en && aligned) begin
            cnt_q <= pos + 1'b1;
        end
    end

    // R5: a strobe places the next bit at position 1
    a_r5_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && frame_sync) |=> (cnt_q == CNT_W'(1)));

    // R6: without a strobe the hunt state is kept
    a_r6_stay_hunt: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HUNT && !(bit_en && frame_sync)) |=> (state_q == ST_HUNT));
endmodule

// File: rtl/tsi_subst.sv
module tsi_subst
    import tsi_pkg::*;
#(
    parameter int unsigned SLOTS = NUM_SLOTS,
    parameter int unsigned WIDTH = SLOT_BITS
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            bit_en,
    input  logic                            tx_in,
    input  logic                            aligned,
    input  logic [$clog2(SLOTS*WIDTH)-1:0]  pos,
    input  logic [SLOTS-1:0]                sel_mask,
    input  logic [WIDTH-1:0]                code,
    output logic                            tx_out
);
    localparam int unsigned CNT_W = $clog2(SLOTS * WIDTH);
    localparam int unsigned BIT_W = $clog2(WIDTH);

    logic             hold_sel;
    logic [WIDTH-1:0] hold_code;
    logic             boundary;
    logic             cur_sel;
    logic [WIDTH-1:0] cur_code;
    logic [BIT_W-1:0] bit_idx;
    logic [CNT_W-BIT_W-1:0] slot_idx;
    logic             next_bit;

    assign bit_idx  = pos[BIT_W-1:0];
    assign slot_idx = pos[CNT_W-1:BIT_W];
    assign boundary = aligned && (bit_idx == '0);
    assign cur_sel  = boundary ? sel_mask[slot_idx] : hold_sel;
    assign cur_code = boundary ? code : hold_code;

    always_comb begin
        next_bit = tx_in;
        if (aligned && cur_sel) begin
            next_bit = cur_code[BIT_W'(WIDTH - 1) - bit_idx];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_sel  <= 1'b0;
            hold_code <= '0;
            tx_out    <= 1'b0;
        end else if (bit_en) begin
            tx_out <= next_bit;
            if (boundary) begin
                hold_sel  <= sel_mask[slot_idx];
                hold_code <= code;
            end
        end
    end

    // R9: output holds while no bit is presented
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_en |=> $stable(tx_out));

    // R6: unaligned bits are copied straight through
    a_r6_hunt_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && !aligned) |=> (tx_out == $past(tx_in)));

    // R8: sampled select and pattern stay fixed inside an octet
    a_r8_mid_octet: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && aligned && bit_idx != '0) |=> ($stable(hold_sel) && $stable(hold_code)));

    // R1: unselected aligned bits pass through
    a_r1_unselected: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_en && aligned && !cur_sel) |=> (tx_out == $past(tx_in)));
endmodule

// File: rtl/tslot_idle_fill.sv
module tslot_idle_fill
    import tsi_pkg::*;
#(
    parameter int unsigned SLOTS = NUM_SLOTS,
    parameter int unsigned WIDTH = SLOT_BITS
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_en,
    input  logic       frame_sync,
    input  logic       tx_in,
    input  logic       host_we,
    input  logic [7:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       tx_out
);
    localparam int unsigned CNT_W = $clog2(SLOTS * WIDTH);

    logic [WIDTH-1:0] code;
    logic [SLOTS-1:0] sel_mask;
    logic             aligned;
    logic [CNT_W-1:0] pos;

    tsi_regs #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (host_we),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .rdata    (host_rdata),
        .code     (code),
        .sel_mask (sel_mask)
    );

    tsi_slot_ctr #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_ctr (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_en     (bit_en),
        .frame_sync (frame_sync),
        .aligned    (aligned),
        .pos        (pos)
    );

    tsi_subst #(.SLOTS(SLOTS), .WIDTH(WIDTH)) u_subst (
        .clk      (clk),
        .rst_n    (rst_n),
        .bit_en   (bit_en),
        .tx_in    (tx_in),
        .aligned  (aligned),
        .pos      (pos),
        .sel_mask (sel_mask),
        .code     (code),
        .tx_out   (tx_out)
    );
endmodule

// File: tb/test_tslot_idle_fill.sv
module test_tslot_idle_fill;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_en = 1'b0;
    logic       frame_sync = 1'b0;
    logic       tx_in = 1'b0;
    logic       host_we = 1'b0;
    logic [7:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic [7:0] host_rdata;
    logic       tx_out;

    int tests = 0;
    int fails = 0;
    string req = "R6";

    // behavioural reference state
    bit [7:0] m_regs [5];      // index 0 = pattern, 1..4 = select bytes
    bit       m_aligned;
    int       m_cnt;
    bit       m_sel;
    bit [7:0] m_code;
    bit       m_out;

    always #10 clk = ~clk;

    tslot_idle_fill i_tslot_idle_fill (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .frame_sync(frame_sync),
        .tx_in(tx_in), .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .tx_out(tx_out)
    );

    task automatic check(string r, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", r, act, exp, $time);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare at next negedge
    task automatic step(bit en, bit fs, bit d, bit we = 0, bit [7:0] a = 0, bit [7:0] w = 0);
        int p;
        @(negedge clk);
        bit_en = en; frame_sync = fs; tx_in = d;
        host_we = we; host_addr = a; host_wdata = w;
        if (en) begin
            if (m_aligned || fs) begin
                p = fs ? 0 : m_cnt;
                if (p % 8 == 0) begin
                    m_sel  = m_regs[1 + p / 64][(p / 8) % 8];
                    m_code = m_regs[0];
                end
                m_out = m_sel ? m_code[7 - p % 8] : d;
                m_cnt = (p + 1) % 256;
                m_aligned = 1;
            end else begin
                m_out = d;
            end
        end
        if (we && a >= 8'h23 && a <= 8'h27) m_regs[a - 8'h23] = w;
        @(posedge clk);
        @(negedge clk);
        bit_en = 0; frame_sync = 0; host_we = 0;
        check(req, int'(tx_out), int'(m_out));
    endtask

    task automatic wr(bit [7:0] a, bit [7:0] w);
        step(0, 0, 0, 1, a, w);
    endtask

    task automatic run_frame(bit sync, int gap_pct);
        for (int i = 0; i < 256; i++) begin
            while ($urandom_range(99) < gap_pct) step(0, 0, $urandom_range(1));
            step(1, sync && i == 0, $urandom_range(1));
        end
    endtask

    task automatic set_mask(bit [31:0] m);
        for (int i = 0; i < 4; i++) wr(8'h24 + 8'(i), m[i*8 +: 8]);
    endtask

    initial begin
        fork
            begin
                repeat (150000) @(posedge clk);
                fails++;
                $display("FAIL watchdog: actual hung expected finish");
            end
            begin
                repeat (3) @(posedge clk);
                @(negedge clk);
                rst_n = 1'b1;
                // R7: reset values read back as zero
                for (int a = 8'h23; a <= 8'h27; a++) begin
                    host_addr = 8'(a);
                    #1 check("R7", int'(host_rdata), 0);
                end
                check("R7", int'(tx_out), 0);
                // R10: unmapped write ignored and reads zero
                req = "R10";
                wr(8'h22, 8'hFF); wr(8'h28, 8'hFF);
                for (int a = 8'h22; a <= 8'h28; a++) begin
                    host_addr = 8'(a);
                    #1 check("R10", int'(host_rdata), 0);
                end
                // R6: programmed but unaligned -> passthrough
                req = "R6";
                wr(8'h23, 8'hA5); set_mask(32'hFFFF_FFFF);
                for (int i = 0; i < 40; i++) step(1, 0, $urandom_range(1));
                // R2: readback of map
                host_addr = 8'h27; #1 check("R2", int'(host_rdata), 8'hFF);
                // R1 all selected, R4 bit order
                req = "R1"; run_frame(1, 0);
                req = "R4"; wr(8'h23, 8'h80); run_frame(0, 10);
                wr(8'h23, 8'h01); run_frame(0, 0);
                // R2 single edges
                req = "R2"; wr(8'h23, 8'h3C);
                set_mask(32'h0000_0001); run_frame(0, 0);
                set_mask(32'h8000_0000); run_frame(0, 0);
                set_mask(32'h5555_AAAA); run_frame(0, 20);
                // R3 shared code, random mask
                req = "R3"; wr(8'h23, 8'hC3); set_mask($urandom); run_frame(0, 0);
                // R8 writes mid-octet and on boundaries
                req = "R8"; set_mask(32'h0F0F_F0F0);
                for (int i = 0; i < 512; i++) begin
                    bit w = ($urandom_range(7) == 0);
                    step(1, 0, $urandom_range(1), w,
                         8'h23 + 8'($urandom_range(4)), 8'($urandom));
                end
                // R5 resync mid frame
                req = "R5"; set_mask(32'h0000_0003); wr(8'h23, 8'hF0);
                for (int i = 0; i < 37; i++) step(1, 0, $urandom_range(1));
                run_frame(1, 0); run_frame(1, 5);
                // R9 gaps
                req = "R9"; run_frame(0, 50);
                // R1 none selected
                req = "R1"; set_mask(32'h0); run_frame(0, 0);
            end
        join_any
        disable fork;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule